// File: doc/BRIEF.md
# Sync-Tip Slicer and Gate Generator

This block watches a stream of digitized video samples, one per clock, and finds the horizontal sync tip. It compares each sample against a programmable slice level that sits halfway down the sync pulse. The result is a registered slice signal that is low while the video is below that level. A one-clock edge pulse marks the first sample of each sync tip, which is the midpoint of the falling sync edge. After a pulse, further crossings are ignored for a programmable holdoff. This rejects equalizing pulses and noise that would otherwise be taken for a new line.

The edge pulse is the timing reference for three gates: a colour-burst gate, a wider burst gate and a back-porch gate. Downstream clamp, gain and chroma logic use these gates. Each gate has a start offset and a width, both in clocks, counted from the edge pulse. Any of the five internal signals can be routed to either of two independent observation taps.

Top module: `sync_slicer_gates`

## Requirements
- R1: `slice_o` is registered and resets high. In the cycle after a sample strictly below the current slice level, it is low. In the cycle after a sample equal to or above the level, it is high.
- R2: The slice level resets to 36. A write (`thr_we_i` high for one clock) loads `thr_wdata_i`, and samples presented from the next clock onward are compared against the new level.
- R3: `edge_o` is high for exactly one clock, in the same cycle that `slice_o` first goes low after being high, provided the holdoff has expired. It resets low.
- R4: The holdoff resets to 600 and is loaded by `hold_we_i`/`hold_wdata_i`. Let H be the holdoff value when a pulse fires. The next pulse can come no earlier than H+1 clocks after it. A crossing that would come sooner produces no pulse, but `slice_o` still follows the samples.
- R5: Each gate is high in exactly those cycles in which the count of clocks since the latest edge pulse (0 in the pulse cycle) is at least its start and less than start+width. A width of 0 keeps the gate low. All gates are low until the first edge pulse. Start+width must stay below 4096.
- R6: An edge pulse that arrives while a gate is open restarts all gate timing from the new pulse.
- R7: Each tap select picks, without delay: code 0 slice, 1 edge pulse, 2 burst gate, 3 wide burst gate, 4 back-porch gate. The two taps are independent.
- R8: Tap select codes 5, 6 and 7 drive the tap low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 8 | Digitized video sample, one per clock |
| thr_we_i | input | 1 | Slice level write strobe |
| thr_wdata_i | input | 8 | New slice level |
| hold_we_i | input | 1 | Holdoff write strobe |
| hold_wdata_i | input | 12 | New holdoff in clocks |
| burst_start_i | input | 12 | Burst gate start offset |
| burst_width_i | input | 12 | Burst gate width |
| wide_start_i | input | 12 | Wide burst gate start offset |
| wide_width_i | input | 12 | Wide burst gate width |
| porch_start_i | input | 12 | Back-porch gate start offset |
| porch_width_i | input | 12 | Back-porch gate width |
| tap_a_sel_i | input | 3 | Tap A signal select |
| tap_b_sel_i | input | 3 | Tap B signal select |
| slice_o | output | 1 | Slice level, low while below threshold |
| edge_o | output | 1 | One-clock sync reference pulse |
| burst_o | output | 1 | Colour-burst gate |
| wide_o | output | 1 | Wide burst gate |
| porch_o | output | 1 | Back-porch gate |
| tap_a_o | output | 1 | Observation tap A |
| tap_b_o | output | 1 | Observation tap B |

## Verification
The bench drives a sample exactly at the slice level and one code below it. A design that used a non-strict compare would flip the slice one code early. It places crossings exactly H and H+1 clocks after a pulse, so an off-by-one holdoff counter either swallows a legal sync or accepts an equalizing pulse. Short lines make a new pulse land while the back-porch gate is still open. A design that did not restart the gates would keep the old gate open through the new line. The bench also sweeps every tap code, so a mis-wired or non-zeroed select shows up as a wrong tap level.

// File: rtl/sslg_pkg.sv
package sslg_pkg;
   localparam int SIG_NUM  = 5;
   localparam int GATE_NUM = 3;
   localparam int TAP_NUM  = 2;

   typedef enum logic [2:0] {
      TAP_SLICE  = 3'd0,
      TAP_EDGE   = 3'd1,
      TAP_BURST  = 3'd2,
      TAP_WBURST = 3'd3,
      TAP_PORCH  = 3'd4
   } tap_e;
endpackage

// File: rtl/sslg_slicer.sv
module sslg_slicer #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 12,
   parameter int THR_RST  = 36,
   parameter int HOLD_RST = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              thr_we_i,
   input  logic [DATA_W-1:0] thr_wdata_i,
   input  logic              hold_we_i,
   input  logic [CNT_W-1:0]  hold_wdata_i,
   output logic              slice_o,
   output logic              edge_o,
   output logic              fire_o
);
   localparam logic [CNT_W:0] GAP_MAX = '1;

   logic [DATA_W-1:0] thr_q;
   logic [CNT_W-1:0]  hold_q;
   logic [CNT_W-1:0]  hold_cnt_q;
   logic              slice_q;
   logic              edge_q;
   logic              below;

   assign below  = (sample_i < thr_q);
   assign fire_o = slice_q & below & (hold_cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q      <= DATA_W'(THR_RST);
         hold_q     <= CNT_W'(HOLD_RST);
         hold_cnt_q <= '0;
         slice_q    <= 1'b1;
         edge_q     <= 1'b0;
      end else begin
         if (thr_we_i)  thr_q  <= thr_wdata_i;
         if (hold_we_i) hold_q <= hold_wdata_i;
         slice_q <= ~below;
         edge_q  <= fire_o;
         if (fire_o)                 hold_cnt_q <= hold_q;
         else if (hold_cnt_q != '0)  hold_cnt_q <= hold_cnt_q - 1'b1;
      end
   end

   assign slice_o = slice_q;
   assign edge_o  = edge_q;

   // checking state: armed one clock after reset, gap since last pulse
   logic           armed_q;
   logic           seen_q;
   logic [CNT_W:0] gap_q;
   logic [CNT_W:0] gap_need_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         seen_q     <= 1'b0;
         gap_q      <= '0;
         gap_need_q <= '0;
      end else begin
         armed_q <= 1'b1;
         if (edge_q) begin
            seen_q <= 1'b1;
            gap_q  <= '0;
         end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + 1'b1;
         end
         if (fire_o) gap_need_q <= {1'b0, hold_q};
      end
   end

   assert_slice_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (slice_q == !$past(below)));

   assert_thr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && $past(thr_we_i) |-> (thr_q == $past(thr_wdata_i)));

   assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q |=> !edge_q);

   assert_edge_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && edge_q |-> (!slice_q && $past(slice_q)));

   assert_holdoff_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q && seen_q |-> (gap_q >= gap_need_q));
endmodule

// File: rtl/sslg_phase.sv
module sslg_phase #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   output logic             run_o,
   output logic [CNT_W-1:0] pos_o
);
   localparam logic [CNT_W-1:0] POS_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= 1'b0;
         pos_o <= '0;
      end else if (fire_i) begin
         run_o <= 1'b1;
         pos_o <= '0;
      end else if (run_o && pos_o != POS_MAX) begin
         pos_o <= pos_o + 1'b1;
      end
   end

   assert_pos_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_o && !fire_i && pos_o != POS_MAX |=> (pos_o == $past(pos_o) + 1'b1));
endmodule

// File: rtl/sslg_gate.sv
module sslg_gate #(
   parameter int CNT_W = 12
) (
   input  logic             run_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             gate_o
);
   logic [CNT_W:0] stop;

   assign stop   = {1'b0, start_i} + {1'b0, width_i};
   assign gate_o = run_i && (pos_i >= start_i) && ({1'b0, pos_i} < stop);
endmodule

// File: rtl/sslg_tap_mux.sv
module sslg_tap_mux #(
   parameter int SIG_NUM = 5,
   parameter int SEL_W   = 3
) (
   input  logic [SIG_NUM-1:0] sigs_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               tap_o
);
   generate
      if ((2 ** SEL_W) == SIG_NUM) begin : g_full
         assign tap_o = sigs_i[sel_i];
      end else begin : g_sparse
         always_comb begin
            tap_o = 1'b0;
            for (int i = 0; i < SIG_NUM; i++) begin
               if (sel_i == SEL_W'(i)) tap_o = sigs_i[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sync_slicer_gates.sv
module sync_slicer_gates
   import sslg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 12,
   parameter int SEL_W    = 3,
   parameter int THR_RST  = 36,
   parameter int HOLD_RST = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              thr_we_i,
   input  logic [DATA_W-1:0] thr_wdata_i,
   input  logic              hold_we_i,
   input  logic [CNT_W-1:0]  hold_wdata_i,
   input  logic [CNT_W-1:0]  burst_start_i,
   input  logic [CNT_W-1:0]  burst_width_i,
   input  logic [CNT_W-1:0]  wide_start_i,
   input  logic [CNT_W-1:0]  wide_width_i,
   input  logic [CNT_W-1:0]  porch_start_i,
   input  logic [CNT_W-1:0]  porch_width_i,
   input  logic [SEL_W-1:0]  tap_a_sel_i,
   input  logic [SEL_W-1:0]  tap_b_sel_i,
   output logic              slice_o,
   output logic              edge_o,
   output logic              burst_o,
   output logic              wide_o,
   output logic              porch_o,
   output logic              tap_a_o,
   output logic              tap_b_o
);
   generate
      if (DATA_W < 1 || THR_RST >= (2 ** DATA_W)) begin : g_bad_thr
         $error("slice level reset value does not fit DATA_W");
      end
      if (CNT_W < 2 || HOLD_RST >= (2 ** CNT_W)) begin : g_bad_hold
         $error("holdoff reset value does not fit CNT_W");
      end
      if (SIG_NUM > (2 ** SEL_W)) begin : g_bad_sel
         $error("SEL_W too narrow for the tap signal set");
      end
   endgenerate

   logic             fire;
   logic             run;
   logic [CNT_W-1:0] pos;

   sslg_slicer #(
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .THR_RST (THR_RST),
      .HOLD_RST(HOLD_RST)
   ) u_slicer (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_i    (sample_i),
      .thr_we_i    (thr_we_i),
      .thr_wdata_i (thr_wdata_i),
      .hold_we_i   (hold_we_i),
      .hold_wdata_i(hold_wdata_i),
      .slice_o     (slice_o),
      .edge_o      (edge_o),
      .fire_o      (fire)
   );

   sslg_phase #(.CNT_W(CNT_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(fire),
      .run_o (run),
      .pos_o (pos)
   );

   // gate bank: index 0 burst, 1 wide burst, 2 back porch
   logic [CNT_W-1:0]    g_start [GATE_NUM];
   logic [CNT_W-1:0]    g_width [GATE_NUM];
   logic [GATE_NUM-1:0] g_out;

   assign g_start[0] = burst_start_i;
   assign g_width[0] = burst_width_i;
   assign g_start[1] = wide_start_i;
   assign g_width[1] = wide_width_i;
   assign g_start[2] = porch_start_i;
   assign g_width[2] = porch_width_i;

   generate
      for (genvar gi = 0; gi < GATE_NUM; gi++) begin : g_gate
         sslg_gate #(.CNT_W(CNT_W)) u_gate (
            .run_i  (run),
            .pos_i  (pos),
            .start_i(g_start[gi]),
            .width_i(g_width[gi]),
            .gate_o (g_out[gi])
         );
      end
   endgenerate

   assign burst_o = g_out[0];
   assign wide_o  = g_out[1];
   assign porch_o = g_out[2];

   logic [SIG_NUM-1:0] tap_sigs;
   logic [SEL_W-1:0]   tap_sel [TAP_NUM];
   logic [TAP_NUM-1:0] tap_out;

   assign tap_sigs[TAP_SLICE]  = slice_o;
   assign tap_sigs[TAP_EDGE]   = edge_o;
   assign tap_sigs[TAP_BURST]  = burst_o;
   assign tap_sigs[TAP_WBURST] = wide_o;
   assign tap_sigs[TAP_PORCH]  = porch_o;
   assign tap_sel[0] = tap_a_sel_i;
   assign tap_sel[1] = tap_b_sel_i;

   generate
      for (genvar ti = 0; ti < TAP_NUM; ti++) begin : g_tap
         sslg_tap_mux #(.SIG_NUM(SIG_NUM), .SEL_W(SEL_W)) u_mux (
            .sigs_i(tap_sigs),
            .sel_i (tap_sel[ti]),
            .tap_o (tap_out[ti])
         );
      end
   endgenerate

   assign tap_a_o = tap_out[0];
   assign tap_b_o = tap_out[1];

   // ---------------- assertions ----------------
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= seen_q | edge_o;
   end

   assert_gates_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q && !edge_o |-> (g_out == '0));

   generate
      for (genvar ai = 0; ai < GATE_NUM; ai++) begin : g_gate_chk
         assert_gate_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
            edge_o && g_start[ai] == '0 && g_width[ai] != '0 |-> g_out[ai]);
         assert_gate_zero_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
            g_width[ai] == '0 |-> !g_out[ai]);
      end
   endgenerate

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |-> (pos == '0));

   assert_tap_a_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tap_a_sel_i == SEL_W'(TAP_EDGE) |-> (tap_a_o == edge_o));

   assert_tap_b_porch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tap_b_sel_i == SEL_W'(TAP_PORCH) |-> (tap_b_o == porch_o));

   assert_tap_a_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tap_a_sel_i >= SEL_W'(SIG_NUM) |-> !tap_a_o);

   assert_tap_b_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tap_b_sel_i >= SEL_W'(SIG_NUM) |-> !tap_b_o);
endmodule

// File: tb/sync_slicer_gates_tb.sv
`timescale 1ns/1ps
module sync_slicer_gates_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  smp = 8'd200;
   logic        thr_we = 1'b0;
   logic [7:0]  thr_wd = 8'd0;
   logic        hold_we = 1'b0;
   logic [11:0] hold_wd = 12'd0;
   logic [11:0] bst = 12'd20, bwd = 12'd8;
   logic [11:0] wst = 12'd15, wwd = 12'd30;
   logic [11:0] pst = 12'd40, pwd = 12'd60;
   logic [2:0]  sel_a = 3'd0, sel_b = 3'd2;
   logic        slice_o, edge_o, burst_o, wide_o, porch_o, tap_a_o, tap_b_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sync_slicer_gates u_dut (
      .clk(clk), .rst_n(rst_n), .sample_i(smp),
      .thr_we_i(thr_we), .thr_wdata_i(thr_wd),
      .hold_we_i(hold_we), .hold_wdata_i(hold_wd),
      .burst_start_i(bst), .burst_width_i(bwd),
      .wide_start_i(wst), .wide_width_i(wwd),
      .porch_start_i(pst), .porch_width_i(pwd),
      .tap_a_sel_i(sel_a), .tap_b_sel_i(sel_b),
      .slice_o(slice_o), .edge_o(edge_o), .burst_o(burst_o),
      .wide_o(wide_o), .porch_o(porch_o),
      .tap_a_o(tap_a_o), .tap_b_o(tap_b_o)
   );

   // ---------- behavioural reference ----------
   int m_thr, m_ho, m_ho_at, m_cyc, m_last, m_since;
   bit m_slice, m_edge, m_had;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_thr = 36; m_ho = 600; m_ho_at = 0; m_cyc = 0; m_last = 0;
         m_since = 0; m_slice = 1; m_edge = 0; m_had = 0;
      end else begin
         bit below, fire;
         m_cyc = m_cyc + 1;
         below = (int'(smp) < m_thr);
         fire  = m_slice && below && (!m_had || (m_cyc - m_last) >= m_ho_at + 1);
         if (fire) begin
            m_had = 1; m_last = m_cyc; m_ho_at = m_ho; m_since = 0;
         end else if (m_had) begin
            m_since = m_since + 1;
         end
         m_edge  = fire;
         m_slice = !below;
         if (thr_we)  m_thr = int'(thr_wd);
         if (hold_we) m_ho  = int'(hold_wd);
      end
   end

   function automatic bit exp_gate(int st, int wd);
      return m_had && (m_since >= st) && (m_since < st + wd);
   endfunction

   function automatic bit exp_tap(int sel);
      case (sel)
         0: return m_slice;
         1: return m_edge;
         2: return exp_gate(int'(bst), int'(bwd));
         3: return exp_gate(int'(wst), int'(wwd));
         4: return exp_gate(int'(pst), int'(pwd));
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(bit got, bit exp, string req, string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: got %0b expected %0b", req, what, $time, got, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(slice_o, m_slice, "R1", "slice");
         chk(edge_o, m_edge, "R3", "edge pulse");
         chk(burst_o, exp_gate(int'(bst), int'(bwd)), "R5", "burst gate");
         chk(wide_o, exp_gate(int'(wst), int'(wwd)), "R5", "wide gate");
         chk(porch_o, exp_gate(int'(pst), int'(pwd)), "R6", "porch gate");
         chk(tap_a_o, exp_tap(int'(sel_a)), (sel_a > 4) ? "R8" : "R7", "tap a");
         chk(tap_b_o, exp_tap(int'(sel_b)), (sel_b > 4) ? "R8" : "R7", "tap b");
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line(int lo_len, int total, int lo, int hi);
      smp = 8'(lo);
      tick(lo_len);
      smp = 8'(hi);
      tick(total - lo_len);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // reset state
      chk(slice_o, 1'b1, "R1", "reset slice");
      chk(edge_o, 1'b0, "R3", "reset edge");
      chk(burst_o | wide_o | porch_o, 1'b0, "R5", "gates before first pulse");
      chk(tap_a_o, 1'b1, "R7", "tap a shows slice");

      // default slice level 36: equal is not below
      smp = 8'd36; tick(1);
      chk(slice_o, 1'b1, "R2", "sample at default level");
      smp = 8'd35; tick(1);
      chk(slice_o, 1'b0, "R2", "sample one below default level");
      chk(edge_o, 1'b1, "R3", "pulse on first low sample");
      tick(1);
      chk(edge_o, 1'b0, "R3", "pulse one clock wide");
      smp = 8'd200; tick(700);

      // normal lines and tap sweep
      for (int k = 0; k < 8; k++) begin
         sel_a = 3'(k); sel_b = 3'(7 - k);
         line(8, 800, 10, 200);
      end
      sel_a = 3'd1; sel_b = 3'd4;

      // equalizing pulses at half-line spacing
      for (int k = 0; k < 8; k++) line(4, 300, 10, 200);
      tick(700);

      // holdoff suppression of an early crossing
      smp = 8'd10; tick(1);
      chk(edge_o, 1'b1, "R4", "pulse after expired holdoff");
      smp = 8'd200; tick(100);
      smp = 8'd10; tick(1);
      chk(edge_o, 1'b0, "R4", "crossing inside holdoff");
      chk(slice_o, 1'b0, "R4", "slice follows suppressed crossing");
      smp = 8'd200; tick(700);

      // holdoff 50: boundary at 50 and 51 clocks
      hold_we = 1'b1; hold_wd = 12'd50; tick(1); hold_we = 1'b0;
      smp = 8'd10; tick(1);
      smp = 8'd200; tick(49);
      smp = 8'd10; tick(1);
      chk(edge_o, 1'b0, "R4", "crossing 50 clocks after pulse, holdoff 50");
      smp = 8'd200; tick(100);
      smp = 8'd10; tick(1);
      smp = 8'd200; tick(50);
      smp = 8'd10; tick(1);
      chk(edge_o, 1'b1, "R4", "crossing 51 clocks after pulse, holdoff 50");
      smp = 8'd200; tick(100);

      // run-time slice level change
      thr_we = 1'b1; thr_wd = 8'd100; tick(1); thr_we = 1'b0;
      smp = 8'd100; tick(1);
      chk(slice_o, 1'b1, "R2", "sample equal to new level");
      smp = 8'd90; tick(1);
      chk(slice_o, 1'b0, "R2", "sample below new level");
      smp = 8'd150; tick(100);
      for (int k = 0; k < 4; k++) line(8, 200, 90, 150);

      // restart of an open gate
      hold_we = 1'b1; hold_wd = 12'd20; tick(1); hold_we = 1'b0;
      smp = 8'd90; tick(1);
      chk(porch_o, 1'b0, "R6", "porch closed at pulse");
      smp = 8'd150; tick(40);
      chk(porch_o, 1'b1, "R5", "porch opens at start");
      tick(29);
      smp = 8'd90; tick(1);
      chk(edge_o, 1'b1, "R6", "new pulse while porch open");
      chk(porch_o, 1'b0, "R6", "porch restarted by new pulse");
      smp = 8'd150; tick(60);
      for (int k = 0; k < 6; k++) line(3, 70, 90, 150);

      // zero width and gate start at the pulse
      bwd = 12'd0; wst = 12'd0; wwd = 12'd5;
      smp = 8'd90; tick(1);
      chk(wide_o, 1'b1, "R5", "gate starting at offset 0");
      chk(burst_o, 1'b0, "R5", "zero width gate");
      smp = 8'd150; tick(60);
      for (int k = 0; k < 3; k++) line(5, 90, 90, 150);

      // no holdoff: toggling input gives alternate-cycle pulses
      hold_we = 1'b1; hold_wd = 12'd0; tick(1); hold_we = 1'b0;
      for (int k = 0; k < 20; k++) begin
         smp = (k % 2 == 0) ? 8'd90 : 8'd150;
         tick(1);
      end
      for (int k = 0; k < 8; k++) begin
         sel_a = 3'(k); sel_b = 3'(k);
         line(6, 120, 90, 150);
      end
      smp = 8'd150; tick(10);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL R3 watchdog: got hung run expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule